// File: doc/BRIEF.md
# USB Host Receive Endpoint Transaction Sequencer

This block runs one receive endpoint of a USB host controller. Software or a DMA engine arms a request. The block then asks a separate token/packet engine to send IN tokens to the target device. The engine reports each handshake back to the block as a response code and, for a data packet, a byte count. The block owns the endpoint's control and status bits: the pending request, the received-packet flag, the automatic clear and re-request behaviour, a packet budget, a NAK limit and a three-strike error rule. It raises sticky status bits and a one-cycle interrupt.

A received packet is held until its flag is cleared. Software can clear it, or the block can clear it once a full-size packet has been drained from the FIFO. Clearing the flag sends the acknowledge to the device. With automatic re-request enabled, clearing the flag also arms the next IN request. The packet budget, or a short packet, stops the chain, so a whole bulk transfer can run without the processor.

Top module: `usb_in_ep_seq`

## Requirements
- R1: `tok_req` is high exactly while a request is pending (`req_pkt`=1) and no received packet is held (`rxrdy`=0). After reset, no token is requested until `arm_req` is pulsed.
- R2: A response with `rsp_code`=0 (DATA) while `tok_req` is high sets `rxrdy`, clears `req_pkt`, and pulses `rx_irq` for one cycle. All outputs are registered and show the change one cycle after the response.
- R3: `ack_send` pulses for one cycle in the same cycle that `rxrdy` goes from 1 to 0, and at no other time.
- R4: When `auto_clr_en`=1, `rxrdy` clears by itself on the `fifo_rd` strobe that completes `max_pkt` reads of a packet whose byte count equalled `max_pkt`. A shorter packet is never cleared this way.
- R5: When `auto_req`=1 at the moment `rxrdy` clears, `req_pkt` is set again in that same cycle.
- R6: Each DATA response decrements a nonzero `pkt_cnt`. The DATA response that takes it from 1 to 0 clears `auto_req`, so exactly the programmed number of packets is received.
- R7: With `pkt_cnt`=0, `auto_req` stays set across full-size packets. A DATA response with `rsp_bytes` < `max_pkt` clears it.
- R8: A NAK (`rsp_code`=1) leaves the request pending. The NAK that brings the count to `nak_limit` clears `req_pkt`, sets `sts[2]` and pulses `rx_irq`. When `nak_limit`=0, NAKs are retried without limit.
- R9: A STALL (`rsp_code`=2) clears `req_pkt` at once, sets `sts[0]`, pulses `rx_irq`, and is not retried.
- R10: A timeout (`rsp_code`=3) or a CRC/bit-stuff error (`rsp_code`=4) leaves the request pending. The third such failure clears `req_pkt`, sets `sts[1]` and pulses `rx_irq`.
- R11: The NAK count and the error count both restart from zero on each DATA response, on each `arm_req`, and on each automatic re-request.
- R12: Each bit of `sts` (0 stalled, 1 error, 2 NAK timeout) stays set until a one-cycle pulse on the matching bit of `sts_clr`. If a hardware set and a clear land on the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_req | input | 1 | Pulse: arm a request for an IN transaction |
| auto_req_wr | input | 1 | Pulse: write `auto_req_val` into the auto-request flag |
| auto_req_val | input | 1 | Value written to the auto-request flag |
| auto_clr_en | input | 1 | Enable automatic clearing of `rxrdy` after a full-size drain |
| max_pkt | input | MPW | Maximum packet size in bytes |
| nak_limit | input | NLW | NAKs tolerated per request; 0 means unlimited |
| pkt_cnt_wr | input | 1 | Pulse: load `pkt_cnt_val` into the packet budget |
| pkt_cnt_val | input | CNTW | Packet budget value |
| rxrdy_clr | input | 1 | Pulse: software clears the received-packet flag |
| fifo_rd | input | 1 | One-byte read strobe from the FIFO consumer |
| sts_clr | input | 3 | Per-bit clear pulses for `sts` |
| tok_req | output | 1 | Request to the token engine to send an IN token |
| rsp_valid | input | 1 | Handshake result valid |
| rsp_code | input | 3 | 0 DATA, 1 NAK, 2 STALL, 3 timeout, 4 CRC/bit-stuff |
| rsp_bytes | input | MPW | Byte count of a DATA packet |
| req_pkt | output | 1 | Request pending |
| rxrdy | output | 1 | A received packet is held in the FIFO |
| auto_req | output | 1 | Auto-request flag |
| pkt_cnt | output | CNTW | Remaining packet budget |
| sts | output | 3 | Sticky status: 0 stalled, 1 error, 2 NAK timeout |
| rx_irq | output | 1 | One-cycle endpoint interrupt |
| ack_send | output | 1 | One-cycle request to acknowledge the held packet |

## Verification
The status register can receive a hardware set and a software clear on the same bit in the same cycle. This happens when a STALL response arrives in the cycle that `sts_clr[0]` is pulsed. The bench drives both in one cycle and expects `sts[0]` to stay at 1. A later clear pulse on its own must then bring the bit to 0, and a clear aimed at a different bit must leave it untouched.

// File: rtl/usb_in_pkg.sv
// Shared types for the receive endpoint sequencer.
// Assumes the token engine encodes its handshake results with these values.
package usb_in_pkg;
    typedef enum logic [2:0] {
        RSP_DATA    = 3'd0,
        RSP_NAK     = 3'd1,
        RSP_STALL   = 3'd2,
        RSP_TIMEOUT = 3'd3,
        RSP_CRC     = 3'd4
    } rsp_e;

    localparam int STS_STALL = 0;
    localparam int STS_ERR   = 1;
    localparam int STS_NAKTO = 2;
endpackage

// File: rtl/usb_in_retry_ctr.sv
// Counts failed attempts of one kind and flags the attempt that reaches the limit.
// Assumes a limit of zero disables the flag (unlimited retries).
// The clear input has priority over increment; the counter restarts on a hit.
module usb_in_retry_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    // Hit when this increment would make the count equal the limit.
    assign hit = inc && (limit != '0) && (cnt == limit - W'(1));

    // Attempt counter with restart on clear or on reaching the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr || hit) cnt <= '0;
        else if (inc)        cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/usb_in_rx_drain.sv
// Tracks FIFO reads of the held packet and detects a completed full-size drain.
// Assumes one byte per read strobe. Reads are counted only while a packet is held.
module usb_in_rx_drain #(
    parameter int MPW = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           len_full,
    input  logic           rd,
    input  logic           held,
    input  logic           auto_en,
    input  logic [MPW-1:0] max_pkt,
    output logic           done
);
    logic [MPW-1:0] rd_cnt;
    logic           full_q;

    // Done on the read that completes max_pkt bytes of a full-size packet.
    assign done = auto_en && held && full_q && rd && (rd_cnt + MPW'(1) == max_pkt);

    // Restart the read count per packet and remember whether it was full size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            full_q <= 1'b0;
        end else if (start) begin
            rd_cnt <= '0;
            full_q <= len_full;
        end else if (rd && held) begin
            rd_cnt <= rd_cnt + MPW'(1);
        end
    end
endmodule

// File: rtl/usb_in_ep_seq.sv
// Receive endpoint transaction sequencer for a USB host.
// Holds the request, received-packet, auto-request and status state of one
// endpoint. It drives the token engine through tok_req and consumes its
// handshake results. Assumes rsp_valid is only meaningful while tok_req is high.
module usb_in_ep_seq
    import usb_in_pkg::*;
#(
    parameter int MPW       = 11,
    parameter int CNTW      = 16,
    parameter int NLW       = 8,
    parameter int ERR_TRIES = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm_req,
    input  logic            auto_req_wr,
    input  logic            auto_req_val,
    input  logic            auto_clr_en,
    input  logic [MPW-1:0]  max_pkt,
    input  logic [NLW-1:0]  nak_limit,
    input  logic            pkt_cnt_wr,
    input  logic [CNTW-1:0] pkt_cnt_val,
    input  logic            rxrdy_clr,
    input  logic            fifo_rd,
    input  logic [2:0]      sts_clr,
    output logic            tok_req,
    input  logic            rsp_valid,
    input  logic [2:0]      rsp_code,
    input  logic [MPW-1:0]  rsp_bytes,
    output logic            req_pkt,
    output logic            rxrdy,
    output logic            auto_req,
    output logic [CNTW-1:0] pkt_cnt,
    output logic [2:0]      sts,
    output logic            rx_irq,
    output logic            ack_send
);
    localparam int ERRW = $clog2(ERR_TRIES + 1);

    logic rsp_fire, ev_data, ev_nak, ev_stall, ev_err;
    logic nak_hit, err_hit, drain_done, rx_clear, rearm, ctr_clr, short_pkt;

    // Token request while a request is pending and the FIFO slot is free.
    assign tok_req  = req_pkt && !rxrdy;

    // Decode the handshake result accepted this cycle.
    assign rsp_fire = rsp_valid && tok_req;
    assign ev_data  = rsp_fire && (rsp_code == RSP_DATA);
    assign ev_nak   = rsp_fire && (rsp_code == RSP_NAK);
    assign ev_stall = rsp_fire && (rsp_code == RSP_STALL);
    assign ev_err   = rsp_fire && ((rsp_code == RSP_TIMEOUT) || (rsp_code == RSP_CRC));

    // Clearing of the held packet and the automatic re-request it may trigger.
    assign rx_clear  = rxrdy && (rxrdy_clr || drain_done);
    assign rearm     = rx_clear && auto_req;
    assign ctr_clr   = ev_data || arm_req || rearm;
    assign short_pkt = rsp_bytes < max_pkt;

    usb_in_retry_ctr #(.W(NLW)) u_nak_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ev_nak),
        .limit (nak_limit),
        .hit   (nak_hit)
    );

    usb_in_retry_ctr #(.W(ERRW)) u_err_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ev_err),
        .limit (ERRW'(ERR_TRIES)),
        .hit   (err_hit)
    );

    usb_in_rx_drain #(.MPW(MPW)) u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ev_data),
        .len_full (rsp_bytes == max_pkt),
        .rd       (fifo_rd),
        .held     (rxrdy),
        .auto_en  (auto_clr_en),
        .max_pkt  (max_pkt),
        .done     (drain_done)
    );

    // Request flag: arming wins over any terminating response.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         req_pkt <= 1'b0;
        else if (arm_req || rearm)                          req_pkt <= 1'b1;
        else if (ev_data || ev_stall || nak_hit || err_hit) req_pkt <= 1'b0;
    end

    // Received-packet flag, set by DATA and cleared by software or drain.
    always_ff @(posedge clk) begin
        if (!rst_n)        rxrdy <= 1'b0;
        else if (ev_data)  rxrdy <= 1'b1;
        else if (rx_clear) rxrdy <= 1'b0;
    end

    // Packet budget: loaded by software, decremented on each received packet.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pkt_cnt <= '0;
        else if (pkt_cnt_wr)                pkt_cnt <= pkt_cnt_val;
        else if (ev_data && pkt_cnt != '0)  pkt_cnt <= pkt_cnt - CNTW'(1);
    end

    // Auto-request flag: ends at the last budgeted packet or at a short packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            auto_req <= 1'b0;
        else if (auto_req_wr)
            auto_req <= auto_req_val;
        else if (ev_data && ((pkt_cnt == CNTW'(1)) || ((pkt_cnt == '0) && short_pkt)))
            auto_req <= 1'b0;
    end

    // Sticky status bits; a hardware set overrides a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts[STS_STALL] <= (sts[STS_STALL] && !sts_clr[STS_STALL]) || ev_stall;
            sts[STS_ERR]   <= (sts[STS_ERR]   && !sts_clr[STS_ERR])   || err_hit;
            sts[STS_NAKTO] <= (sts[STS_NAKTO] && !sts_clr[STS_NAKTO]) || nak_hit;
        end
    end

    // One-cycle interrupt and acknowledge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_irq   <= 1'b0;
            ack_send <= 1'b0;
        end else begin
            rx_irq   <= ev_data || ev_stall || nak_hit || err_hit;
            ack_send <= rx_clear;
        end
    end
endmodule

// File: rtl/usb_in_ep_seq_chk.sv
// Temporal checks on the sequencer's ports, attached to every instance by bind.
module usb_in_ep_seq_chk
    import usb_in_pkg::*;
#(
    parameter int CNTW = 16,
    parameter int NLW  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            arm_req,
    input logic [NLW-1:0]  nak_limit,
    input logic            pkt_cnt_wr,
    input logic [2:0]      sts_clr,
    input logic            tok_req,
    input logic            rsp_valid,
    input logic [2:0]      rsp_code,
    input logic            req_pkt,
    input logic            rxrdy,
    input logic            auto_req,
    input logic [CNTW-1:0] pkt_cnt,
    input logic [2:0]      sts,
    input logic            ack_send
);
    AST_RXRDY_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxrdy) |-> $past(rsp_valid && tok_req && rsp_code == RSP_DATA)); // R2
    AST_ACK_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ack_send |-> $fell(rxrdy)); // R3
    AST_REARM_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rxrdy) && $past(auto_req)) |-> req_pkt); // R5
    AST_BUDGET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && tok_req && rsp_code == RSP_DATA && pkt_cnt != '0 && !pkt_cnt_wr)
        |=> (pkt_cnt == $past(pkt_cnt) - CNTW'(1))); // R6
    AST_NAK_UNLIMITED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && tok_req && rsp_code == RSP_NAK && nak_limit == '0) |=> req_pkt); // R8
    AST_STALL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && tok_req && rsp_code == RSP_STALL && !arm_req)
        |=> (!req_pkt && sts[STS_STALL])); // R9
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts != '0) |=> ((sts & $past(sts & ~sts_clr)) == $past(sts & ~sts_clr))); // R12
endmodule

bind usb_in_ep_seq usb_in_ep_seq_chk #(.CNTW(CNTW), .NLW(NLW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_req    (arm_req),
    .nak_limit  (nak_limit),
    .pkt_cnt_wr (pkt_cnt_wr),
    .sts_clr    (sts_clr),
    .tok_req    (tok_req),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .req_pkt    (req_pkt),
    .rxrdy      (rxrdy),
    .auto_req   (auto_req),
    .pkt_cnt    (pkt_cnt),
    .sts        (sts),
    .ack_send   (ack_send)
);

// File: tb/usb_in_ep_seq_test.sv
module usb_in_ep_seq_test;
    localparam int MPW = 11, CNTW = 16, NLW = 8;
    localparam int MAXP = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic arm_req = 0, auto_req_wr = 0, auto_req_val = 0, auto_clr_en = 0;
    logic [MPW-1:0] max_pkt = MPW'(MAXP);
    logic [NLW-1:0] nak_limit = '0;
    logic pkt_cnt_wr = 0;
    logic [CNTW-1:0] pkt_cnt_val = '0;
    logic rxrdy_clr = 0, fifo_rd = 0;
    logic [2:0] sts_clr = '0;
    logic tok_req, rsp_valid = 0;
    logic [2:0] rsp_code = '0;
    logic [MPW-1:0] rsp_bytes = '0;
    logic req_pkt, rxrdy, auto_req, rx_irq, ack_send;
    logic [CNTW-1:0] pkt_cnt;
    logic [2:0] sts;

    int nchk = 0, nerr = 0;

    always #4 clk = ~clk;

    usb_in_ep_seq #(.MPW(MPW), .CNTW(CNTW), .NLW(NLW)) uut (
        .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .auto_req_wr(auto_req_wr),
        .auto_req_val(auto_req_val), .auto_clr_en(auto_clr_en), .max_pkt(max_pkt),
        .nak_limit(nak_limit), .pkt_cnt_wr(pkt_cnt_wr), .pkt_cnt_val(pkt_cnt_val),
        .rxrdy_clr(rxrdy_clr), .fifo_rd(fifo_rd), .sts_clr(sts_clr), .tok_req(tok_req),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_bytes(rsp_bytes),
        .req_pkt(req_pkt), .rxrdy(rxrdy), .auto_req(auto_req), .pkt_cnt(pkt_cnt),
        .sts(sts), .rx_irq(rx_irq), .ack_send(ack_send)
    );

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic respond(input int code, input int bytes);
        rsp_valid = 1; rsp_code = 3'(code); rsp_bytes = MPW'(bytes);
        step;
        rsp_valid = 0;
    endtask

    task automatic arm;
        arm_req = 1; step; arm_req = 0;
    endtask

    task automatic sw_clear;
        rxrdy_clr = 1; step; rxrdy_clr = 0;
    endtask

    task automatic clear_sts;
        sts_clr = 3'b111; step; sts_clr = 3'b000;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report;
    end

    initial begin
        int got;
        repeat (3) step;
        rst_n = 1; step;
        // R1 reset state, no token before arming
        chk("R1 tok_req at reset", int'(tok_req), 0);
        chk("R1 req_pkt at reset", int'(req_pkt), 0);
        chk("R2 rxrdy at reset", int'(rxrdy), 0);
        chk("R12 sts at reset", int'(sts), 0);
        chk("R6 pkt_cnt at reset", int'(pkt_cnt), 0);
        repeat (3) step;
        chk("R1 idle no token", int'(tok_req), 0);

        // R1/R2 basic receive
        arm;
        chk("R1 token after arm", int'(tok_req), 1);
        respond(0, MAXP);
        chk("R2 rxrdy set", int'(rxrdy), 1);
        chk("R2 req cleared", int'(req_pkt), 0);
        chk("R2 irq pulse", int'(rx_irq), 1);
        chk("R1 token off while held", int'(tok_req), 0);
        step;
        chk("R2 irq one cycle", int'(rx_irq), 0);
        chk("R3 no ack while held", int'(ack_send), 0);
        sw_clear;
        chk("R3 rxrdy cleared", int'(rxrdy), 0);
        chk("R3 ack pulse", int'(ack_send), 1);
        chk("R5 no rearm without auto_req", int'(req_pkt), 0);
        step;
        chk("R3 ack one cycle", int'(ack_send), 0);

        // R4 auto-clear sweep over byte counts
        auto_clr_en = 1;
        for (int b = 1; b <= MAXP; b++) begin
            arm;
            respond(0, b);
            for (int k = 1; k <= MAXP; k++) begin
                fifo_rd = 1; step; fifo_rd = 0;
                chk($sformatf("R4 rxrdy bytes=%0d read=%0d", b, k), int'(rxrdy),
                    (b == MAXP && k == MAXP) ? 0 : 1);
                chk($sformatf("R3 ack bytes=%0d read=%0d", b, k), int'(ack_send),
                    (b == MAXP && k == MAXP) ? 1 : 0);
            end
            if (rxrdy) sw_clear;
        end
        auto_clr_en = 0;

        // R6 packet budget sweep with automatic re-request
        for (int n = 1; n <= 4; n++) begin
            pkt_cnt_wr = 1; pkt_cnt_val = CNTW'(n);
            auto_req_wr = 1; auto_req_val = 1;
            step;
            pkt_cnt_wr = 0; auto_req_wr = 0;
            arm;
            got = 0;
            for (int i = 0; i < 8; i++) begin
                if (!tok_req) break;
                respond(0, MAXP);
                got++;
                sw_clear;
                if (got < n) chk($sformatf("R5 rearm n=%0d pkt=%0d", n, got), int'(req_pkt), 1);
            end
            chk($sformatf("R6 packets n=%0d", n), got, n);
            chk($sformatf("R6 auto_req off n=%0d", n), int'(auto_req), 0);
            chk($sformatf("R6 pkt_cnt n=%0d", n), int'(pkt_cnt), 0);
            chk($sformatf("R6 req idle n=%0d", n), int'(req_pkt), 0);
        end

        // R7 unknown length: full packets keep auto_req, short packet ends it
        pkt_cnt_wr = 1; pkt_cnt_val = '0; auto_req_wr = 1; auto_req_val = 1;
        step;
        pkt_cnt_wr = 0; auto_req_wr = 0;
        arm;
        for (int i = 0; i < 3; i++) begin
            respond(0, MAXP);
            chk("R7 auto_req kept", int'(auto_req), 1);
            sw_clear;
            chk("R5 rearm unknown length", int'(req_pkt), 1);
        end
        respond(0, MAXP - 2);
        chk("R7 short clears auto_req", int'(auto_req), 0);
        sw_clear;
        chk("R7 no rearm after short", int'(req_pkt), 0);

        // R8 NAK limit sweep
        for (int l = 1; l <= 5; l++) begin
            nak_limit = NLW'(l);
            clear_sts;
            arm;
            for (int k = 1; k <= l; k++) begin
                respond(1, 0);
                chk($sformatf("R8 req L=%0d k=%0d", l, k), int'(req_pkt), (k < l) ? 1 : 0);
                chk($sformatf("R8 nakto L=%0d k=%0d", l, k), int'(sts[2]), (k == l) ? 1 : 0);
                chk($sformatf("R8 irq L=%0d k=%0d", l, k), int'(rx_irq), (k == l) ? 1 : 0);
            end
        end
        nak_limit = '0;
        clear_sts;
        arm;
        for (int k = 0; k < 40; k++) respond(1, 0);
        chk("R8 unlimited NAK req", int'(req_pkt), 1);
        chk("R8 unlimited NAK sts", int'(sts), 0);

        // R9 STALL ends the request
        respond(2, 0);
        chk("R9 req cleared", int'(req_pkt), 0);
        chk("R9 stalled bit", int'(sts), 1);
        chk("R9 irq", int'(rx_irq), 1);
        repeat (4) step;
        chk("R9 no retry", int'(tok_req), 0);

        // R12 sticky and selective clear
        sts_clr = 3'b010; step; sts_clr = 3'b000;
        chk("R12 other-bit clear ignored", int'(sts), 1);

        // R10 three-strike sweep over timeout/CRC mixes
        for (int p = 0; p < 8; p++) begin
            clear_sts;
            arm;
            for (int k = 1; k <= 3; k++) begin
                respond(((p >> (k - 1)) & 1) ? 4 : 3, 0);
                chk($sformatf("R10 req p=%0d k=%0d", p, k), int'(req_pkt), (k < 3) ? 1 : 0);
                chk($sformatf("R10 err p=%0d k=%0d", p, k), int'(sts[1]), (k == 3) ? 1 : 0);
            end
        end

        // R11 counters restart on data and on arming
        clear_sts;
        arm;
        respond(3, 0); respond(4, 0);
        respond(0, MAXP);
        sw_clear;
        arm;
        respond(3, 0); respond(3, 0);
        chk("R11 err count restarted by data", int'(req_pkt), 1);
        chk("R11 no error yet", int'(sts[1]), 0);
        respond(4, 0);
        chk("R11 third strike after restart", int'(sts[1]), 1);
        nak_limit = NLW'(3);
        clear_sts;
        arm;
        respond(1, 0); respond(1, 0);
        arm;
        respond(1, 0); respond(1, 0);
        chk("R11 nak count restarted by arm", int'(sts[2]), 0);
        respond(1, 0);
        chk("R11 nak limit after restart", int'(sts[2]), 1);
        nak_limit = '0;

        // R12 set wins over a same-cycle clear
        clear_sts;
        arm;
        sts_clr = 3'b001;
        respond(2, 0);
        sts_clr = 3'b000;
        chk("R12 set beats clear", int'(sts[0]), 1);
        repeat (3) step;
        chk("R12 sticky", int'(sts[0]), 1);
        sts_clr = 3'b001; step; sts_clr = 3'b000;
        chk("R12 cleared by pulse", int'(sts[0]), 0);

        report;
    end
endmodule